// File: doc/BRIEF.md
# Eight-Function ALU with Status Flags

This block is a combinational arithmetic-logic unit with a data width set by a parameter (16 bits by default). A 3-bit function code picks one of eight operations. Four use one operand: copy A, copy B, two's-complement negate A, and invert A. Four use two operands: add with carry-in, subtract, bitwise AND, and bitwise OR. The result is driven together with four status outputs: carry, sign, overflow and zero.

All arithmetic goes through a single adder. The operands and carry-in of that adder are conditioned according to the function code. A small status register sits beside the datapath. It captures the four live flags on a clock edge when the load strobe is high, and it holds its value otherwise. This lets a surrounding controller keep the flags from one operation while it starts the next.

Top module: `alu_flagged`

## Requirements
- R1: Function code 3'b000 drives `result` equal to `op_a`. Code 3'b100 drives `result` equal to `op_b`.
- R2: Code 3'b010 computes `op_a + op_b + carry_in`. The bit that leaves the top of the sum appears on `carry_out`. `ovf_out` is high when both operands have the same sign bit and the result has the other sign bit.
- R3: Code 3'b110 computes `op_a + ~op_b + 1`, and `carry_in` has no effect. `carry_out` is the raw adder carry, so it is 1 exactly when `op_a >= op_b` as unsigned numbers. `ovf_out` is high when the operand signs differ and the result sign differs from that of `op_a`.
- R4: Code 3'b001 computes `~op_a + 1`. `ovf_out` is high only when `op_a` is the most negative value (MSB set, all other bits clear). `carry_out` is high only when `op_a` is zero.
- R5: Code 3'b101 drives the bitwise inverse of `op_a`.
- R6: Code 3'b011 drives `op_a & op_b`. Code 3'b111 drives `op_a | op_b`.
- R7: For codes 3'b000, 3'b011, 3'b100, 3'b101 and 3'b111, both `carry_out` and `ovf_out` are 0.
- R8: For every code, `zero_out` is 1 exactly when `result` is all zeros, and `sign_out` equals the MSB of `result`.
- R9: On a rising clock edge with `flags_load` high, `flags_held` takes {carry, sign, overflow, zero} (bit 3 down to bit 0) from the live flags. With `flags_load` low, it keeps its value.
- R10: While `rst_n` is low, `flags_held` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset of the status register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the addition |
| func_sel | input | 3 | Function code |
| flags_load | input | 1 | Capture strobe for the status register |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Live carry flag |
| sign_out | output | 1 | Live sign flag |
| ovf_out | output | 1 | Live signed-overflow flag |
| zero_out | output | 1 | Live zero flag |
| flags_held | output | 4 | Registered flags {carry, sign, overflow, zero} |

## Verification
The assertions sample the combinational outputs on the rising clock edge. They therefore assume that operands, carry-in, function code and load strobe are steady around that edge and free of X. The stimulus changes every input only on the falling edge, and it never leaves an input undriven after reset. The capture and hold properties also assume that the load strobe is a clean single-cycle-qualified level. The stimulus produces a fresh random or directed value for it on each cycle.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        FN_PASS_A = 3'b000,
        FN_NEG_A  = 3'b001,
        FN_ADD    = 3'b010,
        FN_AND    = 3'b011,
        FN_PASS_B = 3'b100,
        FN_NOT_A  = 3'b101,
        FN_SUB    = 3'b110,
        FN_OR     = 3'b111
    } alu_func_e;

    typedef struct packed {
        logic carry;
        logic sign;
        logic ovf;
        logic zero;
    } alu_flags_t;

    function automatic logic is_arith(input alu_func_e fn);
        return (fn == FN_NEG_A) || (fn == FN_ADD) || (fn == FN_SUB);
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] add_x,
    input  logic [WIDTH-1:0] add_z,
    input  logic             add_cin,
    output logic [WIDTH-1:0] add_sum,
    output logic             add_cout,
    output logic             add_ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, add_x} + {1'b0, add_z} + {{WIDTH{1'b0}}, add_cin};
        add_sum  = wide_sum[MSB:0];
        add_cout = wide_sum[WIDTH];
        // Signed overflow: like-signed inputs produce an unlike-signed sum
        add_ovf  = (add_x[MSB] == add_z[MSB]) && (wide_sum[MSB] != add_x[MSB]);
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] lg_a,
    input  logic [WIDTH-1:0] lg_b,
    input  alu_func_e        lg_fn,
    output logic [WIDTH-1:0] lg_out
);
    always_comb begin
        unique case (lg_fn)
            FN_PASS_B: lg_out = lg_b;
            FN_NOT_A:  lg_out = ~lg_a;
            FN_AND:    lg_out = lg_a & lg_b;
            FN_OR:     lg_out = lg_a | lg_b;
            default:   lg_out = lg_a;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  alu_flags_t flags_in,
    output alu_flags_t flags_q
);
    alu_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (load) begin
            flags_d = flags_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [2:0]       func_sel,
    input  logic             flags_load,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             sign_out,
    output logic             ovf_out,
    output logic             zero_out,
    output logic [3:0]       flags_held
);
    localparam int MSB = WIDTH - 1;

    alu_func_e        fn;
    logic [WIDTH-1:0] add_x, add_z, add_sum, logic_out;
    logic             add_cin, add_cout, add_ovf, arith;
    alu_flags_t       live_flags, held_flags;

    assign fn    = alu_func_e'(func_sel);
    assign arith = is_arith(fn);

    // Condition the shared adder inputs for the selected arithmetic function
    always_comb begin
        add_x   = op_a;
        add_z   = op_b;
        add_cin = carry_in;
        unique case (fn)
            FN_NEG_A: begin
                add_x   = ~op_a;
                add_z   = '0;
                add_cin = 1'b1;
            end
            FN_SUB: begin
                add_z   = ~op_b;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .add_x    (add_x),
        .add_z    (add_z),
        .add_cin  (add_cin),
        .add_sum  (add_sum),
        .add_cout (add_cout),
        .add_ovf  (add_ovf)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .lg_a   (op_a),
        .lg_b   (op_b),
        .lg_fn  (fn),
        .lg_out (logic_out)
    );

    always_comb begin
        result           = arith ? add_sum : logic_out;
        live_flags.carry = arith & add_cout;
        live_flags.ovf   = arith & add_ovf;
        live_flags.sign  = result[MSB];
        live_flags.zero  = ~|result;
    end

    assign carry_out = live_flags.carry;
    assign sign_out  = live_flags.sign;
    assign ovf_out   = live_flags.ovf;
    assign zero_out  = live_flags.zero;

    alu_flag_reg u_flag_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (flags_load),
        .flags_in (live_flags),
        .flags_q  (held_flags)
    );

    assign flags_held = held_flags;
endmodule

// File: rtl/alu_flagged_checker.sv
module alu_flagged_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [2:0]       func_sel,
    input logic             flags_load,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             sign_out,
    input logic             ovf_out,
    input logic             zero_out,
    input logic [3:0]       flags_held
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic logic_fn;
    assign logic_fn = (func_sel == 3'b000) || (func_sel == 3'b011) ||
                      (func_sel == 3'b100) || (func_sel == 3'b101) ||
                      (func_sel == 3'b111);

    assert_pass_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b000) |-> (result == op_a));

    assert_pass_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b100) |-> (result == op_b));

    assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b010) |->
        ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})));

    assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b110) |-> (carry_out == (op_a >= op_b)));

    assert_neg_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b001) |-> (ovf_out == (op_a == MOST_NEG)));

    assert_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        logic_fn |-> (!carry_out && !ovf_out));

    assert_zero_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_out |-> !sign_out);

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags_load |=> (flags_held == $past({carry_out, sign_out, ovf_out, zero_out})));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_load |=> $stable(flags_held));
endmodule

bind alu_flagged alu_flagged_checker #(.WIDTH(WIDTH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .carry_in   (carry_in),
    .func_sel   (func_sel),
    .flags_load (flags_load),
    .result     (result),
    .carry_out  (carry_out),
    .sign_out   (sign_out),
    .ovf_out    (ovf_out),
    .zero_out   (zero_out),
    .flags_held (flags_held)
);

// File: tb/test_alu_flagged.sv
module test_alu_flagged;
    localparam int W = 16;
    localparam logic [W-1:0] MINV = 16'h8000;
    localparam logic [W-1:0] MAXV = 16'h7FFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         carry_in = 1'b0;
    logic [2:0]   func_sel = 3'b000;
    logic         flags_load = 1'b0;
    logic [W-1:0] result;
    logic         carry_out, sign_out, ovf_out, zero_out;
    logic [3:0]   flags_held;

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic [2:0]   sel;
        logic [W-1:0] y;
        logic [3:0]   fl;
        logic [3:0]   held;
    } item_t;

    item_t        sb_q[$];
    logic [3:0]   model_held = '0;

    always #4 clk = ~clk;

    alu_flagged #(.WIDTH(W)) i_alu_flagged (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .func_sel(func_sel), .flags_load(flags_load), .result(result),
        .carry_out(carry_out), .sign_out(sign_out), .ovf_out(ovf_out),
        .zero_out(zero_out), .flags_held(flags_held)
    );

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'b000, 3'b100: return "R1";
            3'b010:         return "R2";
            3'b110:         return "R3";
            3'b001:         return "R4";
            3'b101:         return "R5";
            default:        return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural model: returns {y, carry, sign, ovf, zero}
    function automatic logic [W+3:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic ci, input logic [2:0] s);
        logic [W-1:0] y;
        logic c, v;
        int sr;
        c = 1'b0; v = 1'b0;
        case (s)
            3'b000: y = a;
            3'b100: y = b;
            3'b101: y = ~a;
            3'b011: y = a & b;
            3'b111: y = a | b;
            3'b010: begin
                {c, y} = {1'b0, a} + {1'b0, b} + {16'd0, ci};
                sr = int'($signed(a)) + int'($signed(b)) + int'(ci);
                v = (sr > 32767) || (sr < -32768);
            end
            3'b110: begin
                y = a - b;
                c = (a >= b);
                sr = int'($signed(a)) - int'($signed(b));
                v = (sr > 32767) || (sr < -32768);
            end
            default: begin
                y = -a;
                c = (a == '0);
                v = (a == MINV);
            end
        endcase
        return {y, c, y[W-1], v, (y == '0)};
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                         input logic [2:0] s, input logic ld);
        logic [W+3:0] m;
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci; func_sel = s; flags_load = ld;
        m = model(a, b, ci, s);
        if (ld) model_held = m[3:0];
        it.sel = s; it.y = m[W+3:4]; it.fl = m[3:0]; it.held = model_held;
        sb_q.push_back(it);
    endtask

    // Monitor: combinational outputs settle after the falling-edge drive; the
    // status register updates on the rising edge; sample 2 ns after it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                string rq;
                it = sb_q.pop_front();
                rq = req_of(it.sel);
                check(result == it.y, rq, "result", result, it.y);
                check(carry_out == it.fl[3], rq, "carry", 16'(carry_out), 16'(it.fl[3]));
                check(ovf_out == it.fl[1], rq, "overflow", 16'(ovf_out), 16'(it.fl[1]));
                // R8 zero and sign for every function
                check({sign_out, zero_out} == {it.fl[2], it.fl[0]}, "R8", "sign/zero",
                      16'({sign_out, zero_out}), 16'({it.fl[2], it.fl[0]}));
                if (it.sel inside {3'b000, 3'b011, 3'b100, 3'b101, 3'b111})
                    check(!carry_out && !ovf_out, "R7", "logic carry/ovf",
                          16'({carry_out, ovf_out}), 16'd0);
                // R9 register capture / hold
                check(flags_held == it.held, "R9", "flags_held", 16'(flags_held), 16'(it.held));
            end
        end
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] corners[6];
        corners = '{16'h0000, 16'h0001, MAXV, MINV, 16'hFFFF, 16'h5A5A};
        repeat (3) @(negedge clk);
        // R10: register clear under reset, even with load requested
        flags_load = 1'b1; op_a = '0; func_sel = 3'b001;
        @(negedge clk);
        check(flags_held == 4'd0, "R10", "reset flags_held", 16'(flags_held), 16'd0);
        flags_load = 1'b0;
        rst_n = 1'b1;

        // Directed corners, all functions, both carry-in values
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int c = 0; c < 2; c++)
                        apply(corners[i], corners[j], c[0], s[2:0], (i + j + c) % 3 == 0);

        // R3: carry_in has no effect on subtraction
        apply(16'h0005, 16'h0005, 1'b1, 3'b110, 1'b1);
        apply(16'h0005, 16'h0005, 1'b0, 3'b110, 1'b1);
        // R4: negate most-negative and zero
        apply(MINV, 16'h1234, 1'b0, 3'b001, 1'b1);
        apply(16'h0000, 16'h0000, 1'b1, 3'b001, 1'b1);
        // R9: hold while other operations run
        for (int k = 0; k < 8; k++) apply(16'hFFFF, 16'h0001, 1'b1, k[2:0], 1'b0);

        // Random stress
        for (int n = 0; n < 4000; n++)
            apply(16'($urandom), 16'($urandom), 1'($urandom), 3'($urandom), 1'($urandom));

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule